// File: doc/BRIEF.md
# Packed Element Register Accessor

This block holds a bank of 64-bit registers and treats the whole bank as one flat byte array in which vector elements are packed back to back. A caller names a starting register, an element number, a position inside a sub-vector, an element width code and a sub-vector length code. The block turns these into a byte address, picks the register word and the byte lanes the element covers, and reads or writes just those lanes. Elements of 8, 16, 32 or 64 bits are packed with no gaps, so several elements can share one register and one element can sit at any aligned position inside a word.

Writes arrive on a valid/ready port and take effect at the clock edge that accepts them. Only the addressed lanes change; every other byte of the target word and every other register is left as it was. Reads are combinational and return the element sign-extended or zero-extended to 64 bits, as selected by a signedness input. An access whose register falls beyond the last register does nothing on the write side and reads as zero with an out-of-range flag. The write port never applies back-pressure after reset: `wr_ready` is low while reset is asserted and from the first clock edge after release it stays high, so a write is taken on every edge where `wr_valid` is high.

Top module: `pkd_elem_rf`

## Requirements
- R1: The width code selects the element size: 2'b01 is 8 bits, 2'b10 is 16 bits, 2'b11 is 32 bits and 2'b00 is the full 64-bit word; a write stores only the low bits of `wr_data` that fit the element.
- R2: The byte address is base*8 + (index*L + sub)*B, where B is the element size in bytes and L is the sub-vector length, with length code c meaning L = c+1 (code 2'b00 gives L = 1); the register is the address divided by 8 and the lane is the address modulo 8.
- R3: A write changes only the bytes of the addressed element; the other bytes of that register and all other registers keep their values.
- R4: A write accepted at a rising edge is visible on `rd_data` from that edge on; before the edge the read path still shows the old value, and without an accepted write a read with unchanged inputs returns unchanged data.
- R5: With `rd_signed` high the element is sign-extended to 64 bits from its top bit, otherwise zero-extended.
- R6: With the 64-bit width code, element i of a vector at base b is the whole register b+i.
- R7: An access whose register number is at or above the register count does not wrap: a write there changes nothing, and a read returns zero with `rd_oob` high.
- R8: Reset clears every register to zero; `wr_ready` is low during reset and high from the first rising edge after reset is released.
- R9: Four 16-bit elements with sub-vector length 1 fill one register exactly, element 0 in the lowest bytes, and leave the next register untouched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Write request |
| wr_ready | output | 1 | Write port can accept |
| wr_base | input | REGW (7) | Starting register of the written vector |
| wr_index | input | IDXW (6) | Element number within the vector |
| wr_sub | input | 2 | Position inside the sub-vector |
| wr_etype | input | 2 | Element width code for the write |
| wr_svcode | input | 2 | Sub-vector length code for the write |
| wr_data | input | 64 | Element value, low bits used |
| rd_base | input | REGW (7) | Starting register of the read vector |
| rd_index | input | IDXW (6) | Element number within the vector |
| rd_sub | input | 2 | Position inside the sub-vector |
| rd_etype | input | 2 | Element width code for the read |
| rd_svcode | input | 2 | Sub-vector length code for the read |
| rd_signed | input | 1 | 1 selects sign extension, 0 zero extension |
| rd_data | output | 64 | Extended element value |
| rd_oob | output | 1 | Read register lies beyond the bank |

## Verification
A read result is due in the same cycle as its address, since the read path has no register; a write is due one rising edge after it is presented with `wr_valid` high. The bench therefore changes inputs 1 ns after each falling edge and its monitor compares `rd_data` 2 ns after that same falling edge, so a write launched at one falling edge is read back at the next one, and a read driven alongside a pending write is expected to show the old contents. Expected values come from a byte-array model in the bench that applies the address formula of R2 directly.

// File: rtl/pkd_elem_pkg.sv
package pkd_elem_pkg;

  localparam int WORD_BITS  = 64;
  localparam int WORD_BYTES = 8;

  typedef enum logic [1:0] {
    ET_FULL = 2'b00,
    ET_BYTE = 2'b01,
    ET_HALF = 2'b10,
    ET_WORD = 2'b11
  } etype_e;

  // log2 of the element size in bytes
  function automatic logic [1:0] elem_lg2(input logic [1:0] code);
    case (etype_e'(code))
      ET_BYTE: return 2'd0;
      ET_HALF: return 2'd1;
      ET_WORD: return 2'd2;
      default: return 2'd3;
    endcase
  endfunction

  // sub-vector length: code 0 means one element per group
  function automatic logic [2:0] sub_len(input logic [1:0] code);
    return {1'b0, code} + 3'd1;
  endfunction

  // lanes occupied by an element that starts at lane 0
  function automatic logic [WORD_BYTES-1:0] lane_mask(input logic [1:0] lg2);
    case (lg2)
      2'd0:    return 8'h01;
      2'd1:    return 8'h03;
      2'd2:    return 8'h0F;
      default: return 8'hFF;
    endcase
  endfunction

endpackage

// File: rtl/pkd_elem_addr.sv
module pkd_elem_addr
  import pkd_elem_pkg::*;
#(
  parameter int NREGS = 128,
  parameter int REGW  = 7,
  parameter int IDXW  = 6
) (
  input  logic [REGW-1:0]       base,
  input  logic [IDXW-1:0]       index,
  input  logic [1:0]            sub,
  input  logic [1:0]            etype,
  input  logic [1:0]            svcode,
  output logic [REGW-1:0]       reg_idx,
  output logic [2:0]            lane,
  output logic [WORD_BYTES-1:0] bmask,
  output logic                  oob
);
  // room for base*8 plus the largest element offset, with headroom
  localparam int ADDRW = REGW + IDXW + 6;
  localparam int RFW   = ADDRW - 3;

  logic [1:0]       lg;
  logic [ADDRW-1:0] slot;
  logic [ADDRW-1:0] boff;
  logic [ADDRW-1:0] addr;
  logic [RFW-1:0]   reg_full;

  always_comb begin
    lg       = elem_lg2(etype);
    slot     = ADDRW'(index) * ADDRW'(sub_len(svcode)) + ADDRW'(sub);
    boff     = slot << lg;
    addr     = (ADDRW'(base) << 3) + boff;
    reg_full = addr[ADDRW-1:3];
    oob      = (reg_full >= RFW'(NREGS));
    reg_idx  = reg_full[REGW-1:0];
    lane     = addr[2:0];
    bmask    = lane_mask(lg) << lane;
  end

endmodule

// File: rtl/pkd_elem_store.sv
module pkd_elem_store
  import pkd_elem_pkg::*;
#(
  parameter int NREGS = 128,
  parameter int REGW  = 7
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [REGW-1:0]       wreg,
  input  logic [WORD_BYTES-1:0] wmask,
  input  logic [WORD_BITS-1:0]  wlanes,
  input  logic [REGW-1:0]       rreg,
  output logic [WORD_BITS-1:0]  rword
);
  logic [WORD_BITS-1:0] mem [NREGS];

  // byte-lane write: untouched lanes keep their stored bytes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NREGS; r++) mem[r] <= '0;
    end else if (we) begin
      for (int b = 0; b < WORD_BYTES; b++) begin
        if (wmask[b]) mem[wreg][b*8 +: 8] <= wlanes[b*8 +: 8];
      end
    end
  end

  assign rword = (int'(rreg) < NREGS) ? mem[rreg] : '0;

endmodule

// File: rtl/pkd_elem_extract.sv
module pkd_elem_extract
  import pkd_elem_pkg::*;
(
  input  logic [WORD_BITS-1:0]  word,
  input  logic [2:0]            lane,
  input  logic [WORD_BYTES-1:0] bmask,
  input  logic [1:0]            etype,
  input  logic                  sgn,
  input  logic                  oob,
  output logic [WORD_BITS-1:0]  data
);
  logic [WORD_BITS-1:0] keep;
  logic [WORD_BITS-1:0] sh;
  logic [WORD_BITS-1:0] fill;
  logic                 msb;

  always_comb begin
    for (int b = 0; b < WORD_BYTES; b++) keep[b*8 +: 8] = {8{bmask[b]}};
    sh = (word & keep) >> {lane, 3'b000};
    case (etype_e'(etype))
      ET_BYTE: begin msb = sh[7];  fill = {{56{1'b1}}, 8'h00};  end
      ET_HALF: begin msb = sh[15]; fill = {{48{1'b1}}, 16'h0000}; end
      ET_WORD: begin msb = sh[31]; fill = {{32{1'b1}}, 32'h0};  end
      default: begin msb = 1'b0;   fill = '0;                   end
    endcase
    data = oob ? '0 : (sh | ((sgn && msb) ? fill : '0));
  end

endmodule

// File: rtl/pkd_elem_rf.sv
module pkd_elem_rf
  import pkd_elem_pkg::*;
#(
  parameter  int NREGS = 128,
  parameter  int IDXW  = 6,
  localparam int REGW  = $clog2(NREGS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_valid,
  output logic                 wr_ready,
  input  logic [REGW-1:0]      wr_base,
  input  logic [IDXW-1:0]      wr_index,
  input  logic [1:0]           wr_sub,
  input  logic [1:0]           wr_etype,
  input  logic [1:0]           wr_svcode,
  input  logic [WORD_BITS-1:0] wr_data,
  input  logic [REGW-1:0]      rd_base,
  input  logic [IDXW-1:0]      rd_index,
  input  logic [1:0]           rd_sub,
  input  logic [1:0]           rd_etype,
  input  logic [1:0]           rd_svcode,
  input  logic                 rd_signed,
  output logic [WORD_BITS-1:0] rd_data,
  output logic                 rd_oob
);
  logic                  ready_q;
  logic [REGW-1:0]       wr_reg;
  logic [2:0]            wr_lane;
  logic [WORD_BYTES-1:0] wr_mask;
  logic                  wr_oob;
  logic                  wr_go;
  logic [WORD_BITS-1:0]  wr_lanes;
  logic [REGW-1:0]       rd_reg;
  logic [2:0]            rd_lane;
  logic [WORD_BYTES-1:0] rd_mask;
  logic [WORD_BITS-1:0]  rd_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end
  assign wr_ready = ready_q;

  pkd_elem_addr #(.NREGS(NREGS), .REGW(REGW), .IDXW(IDXW)) u_wr_addr (
    .base(wr_base), .index(wr_index), .sub(wr_sub), .etype(wr_etype),
    .svcode(wr_svcode), .reg_idx(wr_reg), .lane(wr_lane), .bmask(wr_mask),
    .oob(wr_oob)
  );

  pkd_elem_addr #(.NREGS(NREGS), .REGW(REGW), .IDXW(IDXW)) u_rd_addr (
    .base(rd_base), .index(rd_index), .sub(rd_sub), .etype(rd_etype),
    .svcode(rd_svcode), .reg_idx(rd_reg), .lane(rd_lane), .bmask(rd_mask),
    .oob(rd_oob)
  );

  assign wr_go    = wr_valid && ready_q && !wr_oob;
  assign wr_lanes = wr_data << {wr_lane, 3'b000};

  pkd_elem_store #(.NREGS(NREGS), .REGW(REGW)) u_store (
    .clk(clk), .rst_n(rst_n), .we(wr_go), .wreg(wr_reg), .wmask(wr_mask),
    .wlanes(wr_lanes), .rreg(rd_reg), .rword(rd_word)
  );

  pkd_elem_extract u_extract (
    .word(rd_word), .lane(rd_lane), .bmask(rd_mask), .etype(rd_etype),
    .sgn(rd_signed), .oob(rd_oob), .data(rd_data)
  );

endmodule

// File: rtl/pkd_elem_rf_chk.sv
module pkd_elem_rf_chk #(
  parameter int REGW = 7,
  parameter int IDXW = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_ready,
  input logic            wr_go,
  input logic [REGW-1:0] wr_reg,
  input logic [REGW-1:0] rd_reg,
  input logic [REGW-1:0] rd_base,
  input logic [IDXW-1:0] rd_index,
  input logic [1:0]      rd_sub,
  input logic [1:0]      rd_etype,
  input logic [1:0]      rd_svcode,
  input logic            rd_signed,
  input logic [63:0]     rd_data,
  input logic            rd_oob
);
  logic [REGW+IDXW+6:0] rd_key;
  assign rd_key = {rd_base, rd_index, rd_sub, rd_etype, rd_svcode, rd_signed};

  p_ready_after_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> wr_ready);

  p_oob_reads_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_oob |-> (rd_data == 64'd0));

  p_zero_ext_byte_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_signed && rd_etype == 2'b01) |-> (rd_data[63:8] == 56'd0));

  p_sign_ext_half_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_signed && rd_etype == 2'b10) |-> (rd_data[63:16] == {48{rd_data[15]}}));

  p_other_reg_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_go) && ($past(wr_reg) != rd_reg) && $stable(rd_key)) |-> $stable(rd_data));

  p_idle_read_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wr_go) && $stable(rd_key)) |-> $stable(rd_data));

endmodule

bind pkd_elem_rf pkd_elem_rf_chk #(.REGW(REGW), .IDXW(IDXW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_ready(wr_ready), .wr_go(wr_go),
  .wr_reg(wr_reg), .rd_reg(rd_reg), .rd_base(rd_base), .rd_index(rd_index),
  .rd_sub(rd_sub), .rd_etype(rd_etype), .rd_svcode(rd_svcode),
  .rd_signed(rd_signed), .rd_data(rd_data), .rd_oob(rd_oob)
);

// File: tb/pkd_elem_rf_tb_top.sv
module pkd_elem_rf_tb_top;
  localparam int NREGS = 128;
  localparam int IDXW  = 6;
  localparam int REGW  = 7;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic            rst_n = 1'b0;
  logic            wr_valid = 1'b0;
  logic            wr_ready;
  logic [REGW-1:0] wr_base = '0;
  logic [IDXW-1:0] wr_index = '0;
  logic [1:0]      wr_sub = '0, wr_etype = '0, wr_svcode = '0;
  logic [63:0]     wr_data = '0;
  logic [REGW-1:0] rd_base = '0;
  logic [IDXW-1:0] rd_index = '0;
  logic [1:0]      rd_sub = '0, rd_etype = '0, rd_svcode = '0;
  logic            rd_signed = 1'b0;
  logic [63:0]     rd_data;
  logic            rd_oob;

  pkd_elem_rf #(.NREGS(NREGS), .IDXW(IDXW)) dut_i (.*);

  typedef struct {
    logic [63:0] exp;
    logic        oob;
    string       tag;
  } item_t;

  item_t       sbq[$];
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;
  logic [7:0]  ref_mem [NREGS*8];
  logic [31:0] lf = 32'h1234_5678;

  function automatic int nbytes(int et);
    return (et == 0) ? 8 : (1 << (et - 1));
  endfunction

  function automatic int addr_of(int base, int idx, int sub, int et, int svc);
    return base * 8 + (idx * (svc + 1) + sub) * nbytes(et);
  endfunction

  function automatic void model_write(int base, int idx, int sub, int et, int svc,
                                      logic [63:0] d);
    int a = addr_of(base, idx, sub, et, svc);
    if (a / 8 < NREGS)
      for (int k = 0; k < nbytes(et); k++) ref_mem[a + k] = d[k*8 +: 8];
  endfunction

  function automatic logic [63:0] model_read(int base, int idx, int sub, int et,
                                             int svc, bit sgn);
    int a = addr_of(base, idx, sub, et, svc);
    int n = nbytes(et);
    logic [63:0] v = '0;
    if (a / 8 >= NREGS) return '0;
    for (int k = 0; k < n; k++) v[k*8 +: 8] = ref_mem[a + k];
    if (sgn && n < 8 && v[n*8-1]) v = v | ~((64'd1 << (n * 8)) - 64'd1);
    return v;
  endfunction

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_wr(int base, int idx, int sub, int et, int svc, logic [63:0] d);
    wr_valid  = 1'b1;
    wr_base   = REGW'(base);
    wr_index  = IDXW'(idx);
    wr_sub    = 2'(sub);
    wr_etype  = 2'(et);
    wr_svcode = 2'(svc);
    wr_data   = d;
  endtask

  task automatic push_rd(int base, int idx, int sub, int et, int svc, bit sgn, string tag);
    item_t it;
    rd_base   = REGW'(base);
    rd_index  = IDXW'(idx);
    rd_sub    = 2'(sub);
    rd_etype  = 2'(et);
    rd_svcode = 2'(svc);
    rd_signed = sgn;
    it.exp = model_read(base, idx, sub, et, svc, sgn);
    it.oob = (addr_of(base, idx, sub, et, svc) / 8 >= NREGS);
    it.tag = tag;
    sbq.push_back(it);
  endtask

  // driver: a write is launched after a falling edge and lands at the next rising edge
  task automatic do_write(int base, int idx, int sub, int et, int svc, logic [63:0] d);
    @(negedge clk); #1;
    set_wr(base, idx, sub, et, svc, d);
    @(posedge clk); #1;
    wr_valid = 1'b0;
    model_write(base, idx, sub, et, svc, d);
  endtask

  task automatic do_read(int base, int idx, int sub, int et, int svc, bit sgn, string tag);
    @(negedge clk); #1;
    push_rd(base, idx, sub, et, svc, sgn, tag);
  endtask

  task automatic step_lf();
    lf = lf ^ (lf << 13);
    lf = lf ^ (lf >> 17);
    lf = lf ^ (lf << 5);
  endtask

  // monitor: compares the combinational read 2 ns after each falling edge
  initial begin
    forever begin
      @(negedge clk); #2;
      while (sbq.size() > 0) begin
        item_t it;
        it = sbq.pop_front();
        checks++;
        if (rd_data !== it.exp || rd_oob !== it.oob) begin
          errors++;
          $display("FAIL %s actual=%h/%b expected=%h/%b", it.tag, rd_data, rd_oob,
                   it.exp, it.oob);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R4 watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NREGS * 8; i++) ref_mem[i] = 8'h00;

    // R8: reset state
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk(wr_ready == 1'b0, "R8 ready low in reset", 64'(wr_ready), 64'd0);
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk); #1;
    chk(wr_ready == 1'b1, "R8 ready high after reset", 64'(wr_ready), 64'd1);
    do_read(0, 0, 0, 0, 0, 0, "R8 reg0 cleared");
    do_read(64, 0, 0, 0, 0, 0, "R8 reg64 cleared");
    do_read(127, 0, 0, 0, 0, 0, "R8 reg127 cleared");

    // R9: four halves pack into one register
    for (int i = 0; i < 4; i++)
      do_write(5, i, 0, 2, 0, 64'hDEAD_BEEF_0000_0000 | 64'(16'h1000 * (i + 1) + i));
    do_read(5, 0, 0, 0, 0, 0, "R9 packed word");
    do_read(6, 0, 0, 0, 0, 0, "R9 next reg untouched");

    // R1: element widths
    do_write(10, 3, 0, 1, 0, 64'hFFFF_FFFF_FFFF_FF5A);
    do_read(10, 0, 0, 0, 0, 0, "R1 byte width");
    do_write(11, 1, 0, 3, 0, 64'hFFFF_FFFF_1234_5678);
    do_read(11, 0, 0, 0, 0, 0, "R1 word width");
    do_write(12, 0, 0, 0, 0, 64'h0123_4567_89AB_CDEF);
    do_read(12, 0, 0, 0, 0, 0, "R1 full width");

    // R3: neighbouring bytes kept
    do_write(20, 0, 0, 0, 0, 64'h8877_6655_4433_2211);
    do_write(20, 5, 0, 1, 0, 64'h0000_0000_0000_00C3);
    do_read(20, 0, 0, 0, 0, 0, "R3 byte inside word");
    do_write(20, 1, 0, 2, 0, 64'h0000_0000_0000_BEEF);
    do_read(20, 0, 0, 0, 0, 0, "R3 half inside word");

    // R5: extension
    do_write(40, 0, 0, 0, 0, 64'hFFFF_0000_8000_7F80);
    do_read(40, 0, 0, 1, 0, 1, "R5 byte signed");
    do_read(40, 0, 0, 1, 0, 0, "R5 byte unsigned");
    do_read(40, 1, 0, 1, 0, 1, "R5 positive byte signed");
    do_read(40, 1, 0, 2, 0, 1, "R5 half signed");
    do_read(40, 1, 0, 2, 0, 0, "R5 half unsigned");
    do_read(40, 0, 0, 3, 0, 1, "R5 word signed");
    do_read(40, 1, 0, 3, 0, 1, "R5 upper word signed");
    do_read(40, 0, 0, 3, 0, 0, "R5 word unsigned");

    // R6: full-width elements are whole registers
    do_write(30, 3, 0, 0, 0, 64'hCAFE_F00D_1357_9BDF);
    do_read(33, 0, 0, 0, 0, 0, "R6 element 3 is reg base+3");
    do_read(31, 0, 0, 0, 0, 0, "R6 other reg untouched");
    do_read(30, 3, 0, 0, 0, 1, "R6 same element read");

    // R2: sub-vector lengths
    do_write(50, 2, 1, 2, 2, 64'h0000_0000_0000_5A5A);
    do_read(51, 0, 0, 0, 0, 0, "R2 length 3 half");
    do_read(50, 2, 1, 2, 2, 0, "R2 element readback");
    do_write(60, 5, 3, 1, 3, 64'h0000_0000_0000_0077);
    do_read(62, 0, 0, 0, 0, 0, "R2 length 4 byte");
    do_write(60, 3, 1, 3, 1, 64'h0000_0000_A1B2_C3D4);
    do_read(63, 0, 0, 0, 0, 0, "R2 length 2 word");

    // R7: out of range
    do_write(126, 0, 0, 0, 0, 64'h1111_2222_3333_4444);
    do_write(127, 1, 0, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF);
    do_read(127, 0, 0, 0, 0, 0, "R7 last reg kept");
    do_read(0, 0, 0, 0, 0, 0, "R7 reg0 no wrap");
    do_read(127, 1, 0, 0, 0, 0, "R7 read beyond bank");
    do_read(120, 20, 0, 0, 0, 1, "R7 far read beyond bank");

    // R4: old value before the edge, new value after
    @(negedge clk); #1;
    set_wr(70, 0, 0, 0, 0, 64'h0F0E_0D0C_0B0A_0908);
    push_rd(70, 0, 0, 0, 0, 0, "R4 old value before edge");
    @(posedge clk); #1;
    wr_valid = 1'b0;
    model_write(70, 0, 0, 0, 0, 64'h0F0E_0D0C_0B0A_0908);
    do_read(70, 0, 0, 0, 0, 0, "R4 new value after edge");

    // pseudo-random writes then sweep every register
    for (int n = 0; n < 80; n++) begin
      int b, ix, sb, et, sv;
      logic [63:0] d;
      step_lf(); b  = int'(lf[6:0]); ix = int'(lf[12:7]); sb = int'(lf[14:13]);
      et = int'(lf[16:15]); sv = int'(lf[18:17]);
      if (sb > sv) sb = sv;
      step_lf(); d = {lf, lf ^ 32'hA5A5_5A5A};
      do_write(b, ix, sb, et, sv, d);
    end
    for (int r = 0; r < NREGS; r++) do_read(r, 0, 0, 0, 0, 0, "R3 sweep register");
    for (int n = 0; n < 60; n++) begin
      int b, ix, sb, et, sv;
      step_lf(); b  = int'(lf[6:0]); ix = int'(lf[12:7]); sb = int'(lf[14:13]);
      et = int'(lf[16:15]); sv = int'(lf[18:17]);
      if (sb > sv) sb = sv;
      do_read(b, ix, sb, et, sv, lf[20], "R2 random element");
    end

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule